// File: doc/BRIEF.md
# Third-Order Digital Voltage-Loop Compensator with Sawtooth PWM

This block closes the output-voltage loop of a buck converter in the digital domain. On every pulse of a sample strobe (nominally 10 kHz) it takes a 12-bit conversion of the scaled output voltage and a 12-bit set-point code. It forms their signed difference and evaluates a third-order recursive filter on the present and three previous errors and the three previous control values. The filter's seven integer coefficients come from ports and are held by whatever drives them. All coefficients are pre-scaled so that the leading denominator term is fixed at −128, so the filter sum is divided by 128 with an arithmetic right shift.

The filter result is clamped to the carrier range 0..2000. That clamped value becomes the new duty compare level, and it is also the value kept in the output history, so the recursion cannot wind up beyond what the modulator can produce. A free-running sawtooth counter from 0 to 2000 is compared against the duty level to drive the gate pin. The compare level is reloaded only when the sawtooth wraps, so a new duty value never cuts into a carrier period that is already running.

Top module: `vm_comp_top`

## Requirements
- R1: On a sample strobe the error is formed as the signed 13-bit value set-point code minus ADC code (both inputs unsigned 12-bit).
- R2: On a sample strobe the new control value is floor((A1·e[n] + A2·e[n−1] + A3·e[n−2] + A4·e[n−3] + B2·u[n−1] + B3·u[n−2] + B4·u[n−3]) / 128), computed with an arithmetic right shift by 7 on a wide signed sum, before clamping.
- R3: The control value is clamped to 0 when negative and to 2000 when above 2000. `duty_cmp` never exceeds 2000.
- R4: The clamped value, not the raw sum, is what enters the output history u[n−1..n−3].
- R5: Without a sample strobe, `duty_cmp` and the error and output histories do not change, whatever the ADC, set-point and coefficient ports do.
- R6: While `rst_n` is low, `duty_cmp` is 0, `pwm_out` is low and both histories are zero. Reset is applied asynchronously and released through a two-stage synchroniser.
- R7: The carrier counts 0,1,…,2000 and wraps to 0, for a period of 2001 clocks. `pwm_out` is high while the counter is below the compare level, so it is high for exactly that many clocks per period.
- R8: The compare level used by the modulator loads from `duty_cmp` only on the clock where the counter wraps from 2000 to 0. A duty change in mid-period leaves the rest of that period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-clock strobe that starts a control update |
| adc_code | input | 12 | Measured output-voltage code |
| ref_code | input | 12 | Set-point code |
| coef_a1 | input | 16 | Signed numerator coefficient on e[n] |
| coef_a2 | input | 16 | Signed numerator coefficient on e[n−1] |
| coef_a3 | input | 16 | Signed numerator coefficient on e[n−2] |
| coef_a4 | input | 16 | Signed numerator coefficient on e[n−3] |
| coef_b2 | input | 16 | Signed feedback coefficient on u[n−1] |
| coef_b3 | input | 16 | Signed feedback coefficient on u[n−2] |
| coef_b4 | input | 16 | Signed feedback coefficient on u[n−3] |
| duty_cmp | output | 11 | Clamped control value (0..2000) |
| pwm_out | output | 1 | Gate drive from the sawtooth comparison |

## Verification
Directed updates with only the direct-path coefficient set to unity (128) isolate the error subtraction and both clamp edges from the recursion. A pure integrator setting (direct and first feedback term at 128) is driven into saturation and then given a small negative error. An immediate drop below 2000 separates clamped-history storage from raw-sum storage. Hundreds of strobes with random codes and random signed coefficients on all seven taps then exercise tap ordering, sign handling and the floor rounding of negative sums against a bench model. Counting high clocks over whole carrier periods, and probing the pin just after a mid-period duty change, distinguishes a wrap-aligned reload from an immediate one.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  // number of feed-forward (error) taps and feedback (output) taps
  localparam int unsigned NUM_FF  = 4;
  localparam int unsigned NUM_FB  = 3;
  localparam int unsigned NUM_TAP = NUM_FF + NUM_FB;
endpackage

// File: rtl/vmc_rst_sync.sv
module vmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vmc_iir.sv
module vmc_iir
  import vmc_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CW    = 16,
  parameter int unsigned AW    = 48,
  parameter int unsigned SHIFT = 7,
  parameter int unsigned PMAX  = 2000,
  localparam int unsigned PW   = $clog2(PMAX + 1),
  localparam int unsigned EW   = DW + 1
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic [DW-1:0]                adc_i,
  input  logic [DW-1:0]                ref_i,
  input  logic [NUM_FF-1:0][CW-1:0]    coef_ff_i,
  input  logic [NUM_FB-1:0][CW-1:0]    coef_fb_i,
  output logic [PW-1:0]                duty_o
);
  localparam logic signed [AW-1:0] PMAX_S = AW'(PMAX);

  // error history e[n-1..n-3], output history u[n-1..n-3]
  logic signed [EW-1:0] e_q [NUM_FF-1];
  logic signed [EW-1:0] e_d [NUM_FF-1];
  logic [PW-1:0]        u_q [NUM_FB];
  logic [PW-1:0]        u_d [NUM_FB];

  logic signed [EW-1:0] err;
  logic signed [AW-1:0] samp [NUM_TAP];
  logic signed [AW-1:0] coef [NUM_TAP];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] scaled;
  logic [PW-1:0]        clamped;

  // operand alignment: taps 0..3 error path, 4..6 feedback path
  always_comb begin
    err = $signed({1'b0, ref_i}) - $signed({1'b0, adc_i});
    samp[0] = err;
    for (int k = 1; k < NUM_FF; k++) samp[k] = e_q[k-1];
    for (int k = 0; k < NUM_FB; k++) samp[NUM_FF+k] = $signed({1'b0, u_q[k]});
    for (int k = 0; k < NUM_FF; k++) coef[k] = $signed(coef_ff_i[k]);
    for (int k = 0; k < NUM_FB; k++) coef[NUM_FF+k] = $signed(coef_fb_i[k]);
  end

  // parallel multiply-accumulate, divide by 2^SHIFT, clamp
  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAP; k++) acc = acc + coef[k] * samp[k];
    scaled = acc >>> SHIFT;
    if (scaled < 0)            clamped = '0;
    else if (scaled > PMAX_S)  clamped = PW'(PMAX);
    else                       clamped = scaled[PW-1:0];
  end

  // next state with explicit strobe enable
  always_comb begin
    for (int k = 0; k < NUM_FF-1; k++) e_d[k] = e_q[k];
    for (int k = 0; k < NUM_FB; k++)   u_d[k] = u_q[k];
    if (tick_i) begin
      e_d[0] = err;
      for (int k = 1; k < NUM_FF-1; k++) e_d[k] = e_q[k-1];
      u_d[0] = clamped;
      for (int k = 1; k < NUM_FB; k++)   u_d[k] = u_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_FF-1; k++) e_q[k] <= '0;
      for (int k = 0; k < NUM_FB; k++)   u_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_FF-1; k++) e_q[k] <= e_d[k];
      for (int k = 0; k < NUM_FB; k++)   u_q[k] <= u_d[k];
    end
  end

  assign duty_o = u_q[0];

  // R3: compare level stays inside the carrier range
  assert_duty_range_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    duty_o <= PW'(PMAX));

  // R5: nothing moves between strobes
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_i |=> ($stable(duty_o) && $stable(e_q[0]) && $stable(u_q[NUM_FB-1])));

  // R1: the stored error is the set-point minus the measurement of that strobe
  assert_err_capture_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_i |=> (e_q[0] == $signed({1'b0, $past(ref_i)}) - $signed({1'b0, $past(adc_i)})));

  // R2: with every coefficient zero the update yields zero
  assert_zero_coef_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && coef_ff_i == '0 && coef_fb_i == '0) |=> (duty_o == '0));

  // R4: the freshly stored history term is what the next strobe shifts along
  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_i |=> (u_q[1] == $past(duty_o)));

  // R6: reset holds the output at zero
  assert_reset_zero_R6: assert property (@(posedge clk)
    !rst_ni |-> (duty_o == '0));
endmodule

// File: rtl/vmc_pwm.sv
module vmc_pwm #(
  parameter int unsigned PMAX = 2000,
  localparam int unsigned PW  = $clog2(PMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [PW-1:0] duty_i,
  output logic          pwm_o
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] cmp_q, cmp_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == PW'(PMAX));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    cmp_d = wrap ? duty_i : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign pwm_o = (cnt_q < cmp_q);

  // R7: carrier wraps from the top back to zero
  assert_carrier_wrap_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q == PW'(PMAX)) |=> (cnt_q == '0));

  // R7: a zero compare level keeps the pin low
  assert_zero_cmp_low_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmp_q == '0) |-> !pwm_o);

  // R8: compare level is frozen except at the wrap
  assert_reload_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != PW'(PMAX)) |=> $stable(cmp_q));

  // R6: pin is low in reset
  assert_reset_low_R6: assert property (@(posedge clk)
    !rst_ni |-> !pwm_o);
endmodule

// File: rtl/vm_comp_top.sv
module vm_comp_top
  import vmc_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CW    = 16,
  parameter int unsigned AW    = 48,
  parameter int unsigned SHIFT = 7,
  parameter int unsigned PMAX  = 2000,
  localparam int unsigned PW   = $clog2(PMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic [DW-1:0] adc_code,
  input  logic [DW-1:0] ref_code,
  input  logic [CW-1:0] coef_a1,
  input  logic [CW-1:0] coef_a2,
  input  logic [CW-1:0] coef_a3,
  input  logic [CW-1:0] coef_a4,
  input  logic [CW-1:0] coef_b2,
  input  logic [CW-1:0] coef_b3,
  input  logic [CW-1:0] coef_b4,
  output logic [PW-1:0] duty_cmp,
  output logic          pwm_out
);
  logic                      rst_sync_n;
  logic [NUM_FF-1:0][CW-1:0] coef_ff;
  logic [NUM_FB-1:0][CW-1:0] coef_fb;

  assign coef_ff = {coef_a4, coef_a3, coef_a2, coef_a1};
  assign coef_fb = {coef_b4, coef_b3, coef_b2};

  vmc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vmc_iir #(
    .DW(DW), .CW(CW), .AW(AW), .SHIFT(SHIFT), .PMAX(PMAX)
  ) u_iir (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .tick_i    (sample_tick),
    .adc_i     (adc_code),
    .ref_i     (ref_code),
    .coef_ff_i (coef_ff),
    .coef_fb_i (coef_fb),
    .duty_o    (duty_cmp)
  );

  vmc_pwm #(.PMAX(PMAX)) u_pwm (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .duty_i (duty_cmp),
    .pwm_o  (pwm_out)
  );
endmodule

// File: tb/vm_comp_top_bench.sv
module vm_comp_top_bench;
  localparam int PMAX = 2000;
  localparam int PER  = PMAX + 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_tick;
  logic [11:0] adc_code, ref_code;
  logic signed [15:0] ca1, ca2, ca3, ca4, cb2, cb3, cb4;
  logic [10:0] duty_cmp;
  logic        pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state: e[n-1..n-3], u[n-1..n-3]
  longint me [3];
  longint mu [3];

  always #10 clk = ~clk;

  vm_comp_top u_vm_comp_top (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .adc_code(adc_code), .ref_code(ref_code),
    .coef_a1(ca1), .coef_a2(ca2), .coef_a3(ca3), .coef_a4(ca4),
    .coef_b2(cb2), .coef_b3(cb3), .coef_b4(cb4),
    .duty_cmp(duty_cmp), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(input longint r, input longint a);
    longint e, acc, s, u;
    e = r - a;
    acc = longint'(ca1) * e + longint'(ca2) * me[0] + longint'(ca3) * me[1]
        + longint'(ca4) * me[2] + longint'(cb2) * mu[0] + longint'(cb3) * mu[1]
        + longint'(cb4) * mu[2];
    s = acc >>> 7;
    if (s < 0) u = 0;
    else if (s > PMAX) u = PMAX;
    else u = s;
    me[2] = me[1]; me[1] = me[0]; me[0] = e;
    mu[2] = mu[1]; mu[1] = mu[0]; mu[0] = u;
    return u;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin me[k] = 0; mu[k] = 0; end
  endtask

  task automatic set_coef(input int a1, input int a2, input int a3, input int a4,
                          input int b2, input int b3, input int b4);
    ca1 = 16'(a1); ca2 = 16'(a2); ca3 = 16'(a3); ca4 = 16'(a4);
    cb2 = 16'(b2); cb3 = 16'(b3); cb4 = 16'(b4);
  endtask

  // strobe at a falling edge, result is visible at the next falling edge
  task automatic do_tick(input int r, input int a, input string req, output longint exp);
    exp = model_step(r, a);
    ref_code = 12'(r);
    adc_code = 12'(a);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    chk(longint'(duty_cmp) == exp, req, longint'(duty_cmp), exp);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sample_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(duty_cmp == 0, "R6 duty in reset", duty_cmp, 0);
    chk(pwm_out == 0, "R6 pwm in reset", pwm_out, 0);
    rst_n = 1'b1;
    model_clear();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint exp;
    int hi;
    void'($urandom(32'd20417));
    rst_n = 1'b0;
    sample_tick = 1'b0;
    adc_code = '0;
    ref_code = '0;
    set_coef(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    do_reset();
    chk(duty_cmp == 0, "R6 duty after release", duty_cmp, 0);

    // R1/R3: unity direct path
    set_coef(128, 0, 0, 0, 0, 0, 0);
    do_tick(1000, 400, "R1 positive error", exp);
    chk(duty_cmp == 600, "R1 literal", duty_cmp, 600);
    do_tick(400, 1000, "R3 clamp low", exp);
    chk(duty_cmp == 0, "R3 literal low", duty_cmp, 0);
    do_tick(4095, 0, "R3 clamp high", exp);
    chk(duty_cmp == 2000, "R3 literal high", duty_cmp, 2000);
    // R2: floor of a negative sum (-1/128 -> -1 -> clamp 0), and of 1/128 -> 0
    set_coef(1, 0, 0, 0, 0, 0, 0);
    do_tick(10, 11, "R2 floor negative", exp);
    do_tick(11, 10, "R2 floor small positive", exp);
    // R2: delayed error taps selected one at a time
    set_coef(0, 128, 0, 0, 0, 0, 0);
    do_tick(0, 0, "R2 tap e[n-1]", exp);
    set_coef(0, 0, 0, 128, 0, 0, 0);
    do_tick(0, 0, "R2 tap e[n-3]", exp);

    // R5: no strobe, ports wiggle
    set_coef(128, 0, 0, 0, 0, 0, 0);
    do_tick(1500, 300, "R1 setup for hold", exp);
    for (int k = 0; k < 40; k++) begin
      adc_code = 12'($urandom_range(0, 4095));
      ref_code = 12'($urandom_range(0, 4095));
      set_coef($urandom_range(0, 511) - 256, 5, 7, 9, 64, 3, 1);
      @(negedge clk);
      if (k % 8 == 0) chk(duty_cmp == 1200, "R5 hold", duty_cmp, 1200);
    end
    // histories untouched: with e[n-1] only, result is the pre-hold error
    set_coef(0, 128, 0, 0, 0, 0, 0);
    do_tick(0, 0, "R5 history unchanged", exp);
    chk(duty_cmp == 1200, "R5 history literal", duty_cmp, 1200);

    // R4: integrator saturation and recovery
    set_coef(128, 0, 0, 0, 128, 0, 0);
    for (int k = 0; k < 4; k++) do_tick(3000, 100, "R4 drive into clamp", exp);
    chk(duty_cmp == 2000, "R4 saturated", duty_cmp, 2000);
    do_tick(1000, 1100, "R4 recovery", exp);
    chk(duty_cmp == 1900, "R4 recovery literal", duty_cmp, 1900);

    // R7: period count at duty 100
    set_coef(128, 0, 0, 0, 0, 0, 0);
    do_tick(100, 0, "R7 set duty 100", exp);
    repeat (PER + 2) @(negedge clk);
    count_high(PER, hi);
    chk(hi == 100, "R7 high clocks per period", hi, 100);

    // R8: mid-period change must wait for the wrap
    begin
      bit prev;
      prev = pwm_out;
      for (int k = 0; k < 3 * PER; k++) begin
        @(negedge clk);
        if (!prev && pwm_out) break;
        prev = pwm_out;
      end
    end
    repeat (500) @(negedge clk);
    do_tick(1500, 0, "R8 new duty", exp);
    repeat (10) @(negedge clk);
    chk(pwm_out == 0, "R8 old level kept mid-period", pwm_out, 0);
    begin
      bit prev;
      prev = pwm_out;
      for (int k = 0; k < 2 * PER; k++) begin
        @(negedge clk);
        if (!prev && pwm_out) break;
        prev = pwm_out;
      end
    end
    count_high(PER - 1, hi);
    chk(hi + 1 == 1500, "R8 new level after wrap", hi + 1, 1500);

    // R7: duty 2000 leaves one low clock per period
    do_tick(4000, 0, "R7 set duty full", exp);
    repeat (PER + 2) @(negedge clk);
    count_high(PER, hi);
    chk(hi == 2000, "R7 full duty", hi, 2000);

    // R2: random coefficients and codes
    for (int t = 0; t < 300; t++) begin
      if (t % 25 == 0)
        set_coef($urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256,
                 $urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256,
                 $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                 $urandom_range(0, 255) - 128);
      do_tick($urandom_range(0, 4095), $urandom_range(0, 4095), "R2 random", exp);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    // R6: reset mid-run clears history
    set_coef(128, 0, 0, 0, 0, 0, 0);
    do_tick(1800, 0, "R6 preload", exp);
    do_reset();
    set_coef(0, 128, 0, 0, 128, 0, 0);
    do_tick(0, 0, "R6 history cleared", exp);
    chk(duty_cmp == 0, "R6 history literal", duty_cmp, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule